// File: doc/BRIEF.md
# Bipolar Return-to-Zero Serial Word Receiver

This block receives one channel of a 32-bit avionics serial bus after the line has been converted to logic levels. Two inputs carry the line state. A pulse on `line_hi` is a one and a pulse on `line_lo` is a zero. When both inputs are low the line is null. The system clock oversamples both inputs. Each bit is taken at the start of its return-to-zero pulse, and the spacing between pulse starts is timed against a bit period given in clock cycles.

The receiver has no start bits, so it finds word boundaries from the null time between words. It assembles 32 bits per word and rejects any word with a bit-timing fault, a word-gap fault, a missing bit or a parity fault. Each of these faults gives a one-cycle error pulse. A good word is held for a host, which reads it as two 16-bit halves. The low half must be read first.

Top module: `rz_word_rx`

## Requirements
- R1: A pulse start on `line_hi` is a 1 and a pulse start on `line_lo` is a 0. The first bit of a word lands in bit 0 of the assembled 32-bit word and the 32nd bit lands in bit 31.
- R2: After reset, and after any bit-spacing or word-spacing fault, pulses are ignored until 5×`bit_cycles` clock cycles pass after the last pulse start with no new pulse. This is at least four idle bit periods. The next pulse then begins a new word.
- R3: Between two pulse starts inside a word, a spacing from `bit_cycles - bit_cycles/4` to `bit_cycles + bit_cycles/4` cycles (divisions rounded down) is accepted. Any other spacing pulses `err_bit` for one cycle and discards the word.
- R4: A pulse that arrives after the 32nd bit, before the idle gap of R2 has completed, pulses `err_gap` and discards the word.
- R5: If the idle gap completes after 1 to 31 bits of a word, `err_short` pulses and the partial word is discarded.
- R6: When `parity_odd` is 1, the 32 bits must hold an odd number of ones. When it is 0, they must hold an even number. Bit 31 is the parity bit. A word that fails pulses `err_parity` and is discarded.
- R7: A good 32-bit word sets `word_ready` when its idle gap completes. `host_data` shows bits 15:0 while `rd_hi` is 0 and bits 31:16 while `rd_hi` is 1. A `rd_lo` strobe marks the low half as read. A later `rd_hi` strobe clears `word_ready` on the next cycle. A `rd_hi` strobe before the low half has been read has no effect.
- R8: If a good word arrives while `word_ready` is still set, `overrun` is set and the new word replaces the old one. `overrun` clears together with `word_ready` when the high half is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_hi | input | 1 | Converted line, high state (one) |
| line_lo | input | 1 | Converted line, low state (zero) |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| bit_cycles | input | CW | Bit period in clock cycles |
| rd_lo | input | 1 | Strobe: low half read |
| rd_hi | input | 1 | Strobe: high half read, selects high half on host_data |
| host_data | output | 16 | Half of the held word |
| word_ready | output | 1 | A good word is held |
| overrun | output | 1 | A held word was replaced before it was read |
| err_bit | output | 1 | One-cycle pulse: bit spacing out of window |
| err_gap | output | 1 | One-cycle pulse: word gap too short |
| err_short | output | 1 | One-cycle pulse: word ended early |
| err_parity | output | 1 | One-cycle pulse: parity fault |

## Verification
Suppose the bit counter, the hunt/sync state or the spacing timer goes wrong. The next word then shows a bit-shifted value, an error pulse where none is expected, or no `word_ready`. All three appear at most one idle gap after the word's last pulse. The sweep moves one pulse through spacings on both sides of the acceptance window, so an off-by-one limit turns an accept into `err_bit` or the other way round at a single spacing. Faults in the host-side handshake show up within a few cycles of the read strobes as the wrong half on `host_data` or a `word_ready` or `overrun` that does not clear.

// File: rtl/rz_word_rx.sv
module rz_word_rx #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_hi,
  input  logic          line_lo,
  input  logic          parity_odd,
  input  logic [CW-1:0] bit_cycles,
  input  logic          rd_lo,
  input  logic          rd_hi,
  output logic [15:0]   host_data,
  output logic          word_ready,
  output logic          overrun,
  output logic          err_bit,
  output logic          err_gap,
  output logic          err_short,
  output logic          err_parity
);

  localparam int SW = CW + 3;

  logic [1:0]    hi_s, lo_s;
  logic          act_q;
  logic [SW-1:0] sp;
  logic          synced;
  logic [5:0]    cnt;
  logic [31:0]   sr, hold;
  logic          lo_done;

  wire           act     = hi_s[1] | lo_s[1];
  wire           rise    = act & ~act_q;
  wire           bitv    = hi_s[1];
  wire [SW-1:0]  p_ext   = {3'b000, bit_cycles};
  wire [SW-1:0]  gap_len = (p_ext << 2) + p_ext;
  wire [SW-1:0]  win_lo  = p_ext - (p_ext >> 2);
  wire [SW-1:0]  win_hi  = p_ext + (p_ext >> 2);
  wire           sp_ok   = (sp >= win_lo) && (sp <= win_hi);
  wire           gap_hit = ~rise && (sp == gap_len - SW'(1));
  wire           full    = (cnt == 6'd32);
  wire           par_ok  = (^sr) == parity_odd;
  wire           deliver = synced & gap_hit & full & par_ok;
  wire           hi_done = rd_hi & lo_done & word_ready;

  assign host_data = rd_hi ? hold[31:16] : hold[15:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_s  <= '0;
      lo_s  <= '0;
      act_q <= 1'b0;
    end else begin
      hi_s  <= {hi_s[0], line_hi};
      lo_s  <= {lo_s[0], line_lo};
      act_q <= act;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sp <= '0;
    else if (rise)
      sp <= SW'(1);
    else if (sp < gap_len)
      sp <= sp + SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synced     <= 1'b0;
      cnt        <= '0;
      sr         <= '0;
      err_bit    <= 1'b0;
      err_gap    <= 1'b0;
      err_short  <= 1'b0;
      err_parity <= 1'b0;
    end else begin
      err_bit    <= 1'b0;
      err_gap    <= 1'b0;
      err_short  <= 1'b0;
      err_parity <= 1'b0;
      if (gap_hit) begin
        if (!synced) begin
          synced <= 1'b1;
          cnt    <= '0;
        end else if (full) begin
          cnt <= '0;
          if (!par_ok) err_parity <= 1'b1;
        end else if (cnt != 6'd0) begin
          err_short <= 1'b1;
          cnt       <= '0;
        end
      end else if (rise && synced) begin
        if (full) begin
          err_gap <= 1'b1;
          synced  <= 1'b0;
          cnt     <= '0;
        end else if (cnt == 6'd0 || sp_ok) begin
          sr  <= {bitv, sr[31:1]};
          cnt <= cnt + 6'd1;
        end else begin
          err_bit <= 1'b1;
          synced  <= 1'b0;
          cnt     <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold       <= '0;
      word_ready <= 1'b0;
      lo_done    <= 1'b0;
      overrun    <= 1'b0;
    end else if (deliver) begin
      hold       <= sr;
      word_ready <= 1'b1;
      lo_done    <= 1'b0;
      overrun    <= word_ready & ~hi_done;
    end else if (hi_done) begin
      word_ready <= 1'b0;
      lo_done    <= 1'b0;
      overrun    <= 1'b0;
    end else if (rd_lo && word_ready) begin
      lo_done <= 1'b1;
    end
  end

  AST_CNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 6'd32);  // R1
  AST_HUNT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> cnt == 6'd0);  // R2
  AST_ERR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_bit, err_gap, err_short, err_parity}));  // R3
  AST_NO_READY_ON_GAP_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err_gap |-> !$rose(word_ready));  // R4
  AST_READY_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_ready) |-> ((^hold) == $past(parity_odd)));  // R6
  AST_EARLY_HI_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ready && rd_hi && !lo_done && !deliver) |=> word_ready);  // R7
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(word_ready));  // R8
  AST_OVR_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> word_ready);  // R8

endmodule

// File: tb/rz_word_rx_tb.sv
module rz_word_rx_tb;
  localparam int P = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_hi = 1'b0, line_lo = 1'b0;
  logic        parity_odd = 1'b1;
  logic        rd_lo = 1'b0, rd_hi = 1'b0;
  logic [15:0] host_data;
  logic        word_ready, overrun, err_bit, err_gap, err_short, err_parity;

  int checks = 0, fails = 0;
  int n_bit = 0, n_gap = 0, n_short = 0, n_par = 0;

  always #2.5 clk = ~clk;

  rz_word_rx #(.CW(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_hi(line_hi), .line_lo(line_lo),
    .parity_odd(parity_odd), .bit_cycles(12'(P)), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .host_data(host_data), .word_ready(word_ready), .overrun(overrun),
    .err_bit(err_bit), .err_gap(err_gap), .err_short(err_short),
    .err_parity(err_parity));

  always @(negedge clk) begin
    n_bit   += int'(err_bit);
    n_gap   += int'(err_gap);
    n_short += int'(err_short);
    n_par   += int'(err_parity);
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input int spc);
    @(negedge clk);
    line_hi = b; line_lo = ~b;
    repeat (1) @(negedge clk);
    line_hi = 1'b0; line_lo = 1'b0;
    repeat (spc - 2) @(negedge clk);
  endtask

  task automatic send_word(input logic [31:0] w, input int nbits, input int bad_idx, input int bad_spc);
    for (int i = 0; i < nbits; i++)
      send_bit(w[i % 32], (i + 1 == bad_idx) ? bad_spc : P);
    repeat (5 * P + 8) @(negedge clk);
  endtask

  function automatic logic [31:0] fix_par(input logic [31:0] w, input logic odd);
    logic [31:0] r = w;
    r[31] = odd ^ (^w[30:0]);
    return r;
  endfunction

  task automatic read_word(output logic [31:0] got);
    @(negedge clk);
    rd_lo = 1'b1;
    #0.1 got[15:0] = host_data;
    @(negedge clk);
    rd_lo = 1'b0; rd_hi = 1'b1;
    #0.1 got[31:16] = host_data;
    @(negedge clk);
    rd_hi = 1'b0;
  endtask

  initial begin
    logic [31:0] w, got;
    int b0, g0, s0, p0;
    repeat (4) @(negedge clk);
    chk(word_ready == 0 && overrun == 0, "R7 reset ready", word_ready, 0);
    chk({err_bit, err_gap, err_short, err_parity} == 0, "R3 reset errors", 0, 0);
    rst_n = 1'b1;
    repeat (5 * P + 8) @(negedge clk);

    for (int m = 0; m < 2; m++) begin
      parity_odd = logic'(m);
      for (int k = 0; k < 6; k++) begin
        w = (k == 0) ? 32'h0 : (k == 1) ? 32'hFFFF_FFFF : (k == 2) ? 32'hA5C3_0F71 :
            (k == 3) ? (32'h1 << (k * 5)) : (k == 4) ? 32'h0000_0001 : 32'h7E81_3C24 + k * 32'h0101_0101;
        w = fix_par(w, parity_odd);
        p0 = n_par;
        send_word(w, 32, 0, P);
        chk(word_ready == 1 && n_par == p0, "R6 parity accepted", word_ready, 1);
        read_word(got);
        chk(got == w, "R1 word value", got, w);
        chk(word_ready == 0, "R7 ready cleared", word_ready, 0);
      end
    end

    parity_odd = 1'b1;
    w = fix_par(32'h1234_5678, 1'b1) ^ 32'h8000_0000;
    p0 = n_par;
    send_word(w, 32, 0, P);
    chk(n_par == p0 + 1, "R6 parity error", n_par - p0, 1);
    chk(word_ready == 0, "R6 bad word dropped", word_ready, 0);

    for (int s = 3; s <= 13; s++) begin
      w = fix_par(32'h0F0F_3355 ^ s, 1'b1);
      b0 = n_bit;
      send_word(w, 32, 10, s);
      if (s >= P - P / 4 && s <= P + P / 4) begin
        chk(word_ready == 1 && n_bit == b0, "R3 spacing in window", s, 1);
        read_word(got);
        chk(got == w, "R3 word value", got, w);
      end else begin
        chk(n_bit == b0 + 1 && word_ready == 0, "R3 spacing rejected", s, 0);
      end
    end

    s0 = n_short;
    send_word(32'h5555_5555, 31, 0, P);
    chk(n_short == s0 + 1, "R5 short word", n_short - s0, 1);
    chk(word_ready == 0, "R5 no ready", word_ready, 0);

    g0 = n_gap;
    send_word(fix_par(32'hC001_D00D, 1'b1), 33, 0, P);
    chk(n_gap == g0 + 1, "R4 gap error", n_gap - g0, 1);
    chk(word_ready == 0, "R4 no ready", word_ready, 0);

    w = fix_par(32'h2468_ACE0, 1'b1);
    send_word(w, 32, 0, P);
    chk(word_ready == 1, "R2 resync after error", word_ready, 1);
    @(negedge clk); rd_hi = 1'b1;
    @(negedge clk); rd_hi = 1'b0;
    @(negedge clk);
    chk(word_ready == 1, "R7 early high read ignored", word_ready, 1);
    read_word(got);
    chk(got == w && word_ready == 0, "R7 ordered read", got, w);

    send_word(fix_par(32'h1111_0000, 1'b1), 32, 0, P);
    w = fix_par(32'h0000_2222, 1'b1);
    send_word(w, 32, 0, P);
    chk(overrun == 1 && word_ready == 1, "R8 overrun set", overrun, 1);
    read_word(got);
    chk(got == w, "R8 newer word kept", got, w);
    chk(overrun == 0 && word_ready == 0, "R8 overrun cleared", overrun, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule